// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block keeps the status and control word for each downstream port of a USB host controller root hub, using the OHCI port register model. A parameter sets the number of ports, with two by default. Each port has its own register. The host side reaches them through one 32-bit write path, made of a strobe, a port select and data, and one 32-bit combinational read path with its own port select. Most bits mean one thing when read and another when written. On a read, a bit reports state. On a write, a 1 in the same bit is a command, and a 0 does nothing.

Port power follows one of two switching schemes. In global mode, only the two global power command pulses can change a port's power. In per-port mode, a port whose mask bit is set obeys only its own register's power commands, and a port whose mask bit is clear still obeys only the global pulses. An overcurrent indication drops power. While a port has no power or no device, its connect, enable, suspend and reset state is forced to zero. The connect-change flag is set when a device attaches or detaches. It is also set when an enable, suspend or reset command arrives for a port with nothing connected, so that the driver re-reads the connection state. For a port configured as non-removable, an attach does not set the flag; it is set only when the hub finishes a reset.

Bus signalling, reset pulse timing and suspend/resume signalling are outside this block. Its enable, suspend, reset and power state leave the block as plain level outputs that drive that logic.

Top module: `rh_port_csr`

## Requirements
- R1: After a synchronous reset, with power switching supported, every port reads 0x0000_0000 and every port power output is 0.
- R2: A change of a port's device-present input, when that port's non-removable configuration bit is 0, sets bit 16 (connect change) on the next clock edge. Bit 0 (current connect) reads 1 while the device is present and the port is powered.
- R3: Writing 1 to bit 16 clears the connect-change flag. A write with bit 16 at 0 leaves it unchanged.
- R4: A write with bit 1 (set enable), bit 2 (set suspend) or bit 4 (set reset) to a port whose current connect bit is 0 sets bit 16. The enable, suspend and reset bits stay 0.
- R5: For a port whose non-removable bit is 1, attach and detach do not set bit 16. A hub-reset-done pulse sets bit 16 on such a port while its current connect bit is 1.
- R6: Read bit 9 shows the low-speed input only while current connect is 1, and reads 0 otherwise. A written 1 in bit 9 removes power from a port under per-port control.
- R7: In per-port mode (mode input 1) on a port whose mask bit is 1, a written 1 in bit 8 powers the port, and the global power pulses have no effect on it.
- R8: In global mode (mode 0), or on a port whose mask bit is 0, only the global on/off pulses change power, and register writes to bits 8 and 9 are ignored.
- R9: An active overcurrent input removes power on the next edge and overrides any power-on command in the same cycle. Read bit 3 shows the overcurrent input.
- R10: While a port is unpowered or has no device, bits 0 (connect), 1 (enable), 2 (suspend) and 4 (reset) read 0.
- R11: When power switching is reported as unsupported, bit 8 reads 1 and the port power output is 1, whatever the commands.
- R12: Bits 31 to 17, 15 to 10 and 7 to 5 read 0, and writes to them change nothing.
- R13: On a connected port, writing 1 to bit 1 sets enable, to bit 2 sets suspend, to bit 4 sets reset, to bit 0 clears enable, and to bit 3 clears suspend. A per-port reset-done pulse clears reset and sets enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | PIDX_W | Port selected for the write |
| wr_data | input | 32 | Write data (command bits) |
| rd_port | input | PIDX_W | Port selected for the read |
| rd_data | output | 32 | Status word of the selected port |
| dev_present | input | NPORTS | Device attached, per port |
| dev_lowspeed | input | NPORTS | Attached device is low speed, per port |
| overcurrent | input | NPORTS | Overcurrent detected, per port |
| reset_done | input | NPORTS | Port reset sequence finished (pulse), per port |
| glob_pwr_on | input | 1 | Global power-on command (pulse) |
| glob_pwr_off | input | 1 | Global power-off command (pulse) |
| hub_reset_done | input | 1 | Root hub reset finished (pulse) |
| pwr_per_port_mode | input | 1 | 0 = global switching, 1 = per-port switching |
| pwr_mask | input | NPORTS | Per-port power control mask |
| dev_nonremovable | input | NPORTS | Port has a fixed, non-removable device |
| pwr_sw_supported | input | 1 | 1 = power switching exists |
| port_power | output | NPORTS | Effective port power |
| port_enable | output | NPORTS | Port enabled |
| port_suspend | output | NPORTS | Port suspended |
| port_reset | output | NPORTS | Port reset requested |

## Verification
Some rules are checked by assertions on every clock:
- an overcurrent leaves power off one cycle later;
- a power command from the source the switching scheme does not select cannot turn power on;
- a detached or unpowered port never shows enable, suspend or reset;
- a write-one to the change flag clears it when no set cause is present;
- a command to a disconnected port raises the flag and leaves enable at 0.

Other behaviour only the directed scenarios can show:
- the exact read words;
- the low-speed masking;
- how non-removable ports defer the flag until a hub reset;
- the unsupported-switching override;
- the fact that reserved and zero-valued write bits leave the state unchanged.

// File: rtl/rhp_pkg.sv
// Package: bit positions of the port status/control word and a helper that
// assembles the read word. Assumes a 32-bit host data path.
package rhp_pkg;

    localparam int WORD_W   = 32;
    localparam int B_CONN   = 0;   // read: connected      / write: clear enable
    localparam int B_ENA    = 1;   // read: enabled        / write: set enable
    localparam int B_SUSP   = 2;   // read: suspended      / write: set suspend
    localparam int B_OVC    = 3;   // read: overcurrent    / write: clear suspend
    localparam int B_RST    = 4;   // read: in reset       / write: set reset
    localparam int B_PWR    = 8;   // read: powered        / write: power on
    localparam int B_LOWSPD = 9;   // read: low speed      / write: power off
    localparam int B_CHG    = 16;  // read: connect change / write 1: clear

    // Decoded write commands for one port
    typedef struct packed {
        logic clr_ena;
        logic set_ena;
        logic set_susp;
        logic clr_susp;
        logic set_rst;
        logic pwr_on;
        logic pwr_off;
        logic clr_chg;
    } port_cmd_t;

    // Observable state of one port
    typedef struct packed {
        logic conn;
        logic ena;
        logic susp;
        logic ovc;
        logic rst;
        logic pwr;
        logic lowspd;
        logic chg;
    } port_view_t;

    function automatic logic [WORD_W-1:0] pack_view(input port_view_t v);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[B_CONN]   = v.conn;
        w[B_ENA]    = v.ena;
        w[B_SUSP]   = v.susp;
        w[B_OVC]    = v.ovc;
        w[B_RST]    = v.rst;
        w[B_PWR]    = v.pwr;
        w[B_LOWSPD] = v.lowspd;
        w[B_CHG]    = v.chg;
        return w;
    endfunction

endpackage

// File: rtl/rhp_power_ctl.sv
// Power switch state for one port. Picks the command source (per-port writes
// or global pulses) from the switching mode and the port's mask bit. An
// overcurrent overrides every power-on command. When switching is not
// supported, the effective power is held at 1.
module rhp_power_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic per_port_ctl,
    input  logic sw_supported,
    input  logic cmd_on,
    input  logic cmd_off,
    input  logic glob_on,
    input  logic glob_off,
    input  logic ovc,
    output logic pwr_now,
    output logic pwr_next
);

    logic pps_q;
    logic pps_d;

    // Next power state from the selected command source, overcurrent last
    always_comb begin
        pps_d = pps_q;
        if (per_port_ctl) begin
            if (cmd_on)  pps_d = 1'b1;
            if (cmd_off) pps_d = 1'b0;
        end else begin
            if (glob_on)  pps_d = 1'b1;
            if (glob_off) pps_d = 1'b0;
        end
        if (ovc) pps_d = 1'b0;
    end

    // Power status register
    always_ff @(posedge clk) begin
        if (!rst_n) pps_q <= 1'b0;
        else        pps_q <= pps_d;
    end

    assign pwr_now  = !sw_supported || pps_q;
    assign pwr_next = !sw_supported || pps_d;

    AST_OVC_DROPS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        ovc |=> !pps_q); // R9
    AST_GLOBAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (per_port_ctl && glob_on && !cmd_on && !pps_q) |=> !pps_q); // R7
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_port_ctl && cmd_on && !glob_on && !pps_q) |=> !pps_q); // R8

endmodule

// File: rtl/rhp_status_regs.sv
// Connect, enable, suspend, reset and connect-change state for one port.
// Assumes pwr_now and pwr_next come from rhp_power_ctl, and that the
// device-present input is already synchronous to clk.
module rhp_status_regs
    import rhp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  port_cmd_t cmd,
    input  logic      pres_in,
    input  logic      pwr_now,
    input  logic      pwr_next,
    input  logic      rst_done,
    input  logic      hub_rst_done,
    input  logic      nonremovable,
    output logic      conn,
    output logic      ena,
    output logic      susp,
    output logic      rst,
    output logic      chg
);

    logic pres_q;
    logic live_d;
    logic attach_evt;
    logic cmd_to_idle;
    logic chg_set;

    assign conn        = pres_q && pwr_now;
    assign live_d      = pres_in && pwr_next;
    assign attach_evt  = pres_in ^ pres_q;
    assign cmd_to_idle = (cmd.set_ena || cmd.set_susp || cmd.set_rst) && !conn;
    assign chg_set     = (attach_evt && !nonremovable) || cmd_to_idle ||
                         (hub_rst_done && nonremovable && conn);

    // Track the device-present level to detect attach and detach
    always_ff @(posedge clk) begin
        if (!rst_n) pres_q <= 1'b0;
        else        pres_q <= pres_in;
    end

    // Enable: set by command or reset completion, cleared by command or loss of link
    always_ff @(posedge clk) begin
        if (!rst_n || !live_d)           ena <= 1'b0;
        else if (cmd.clr_ena)            ena <= 1'b0;
        else if (cmd.set_ena && conn)    ena <= 1'b1;
        else if (rst_done && rst)        ena <= 1'b1;
    end

    // Suspend: set and cleared by command, dropped on loss of link
    always_ff @(posedge clk) begin
        if (!rst_n || !live_d)           susp <= 1'b0;
        else if (cmd.clr_susp)           susp <= 1'b0;
        else if (cmd.set_susp && conn)   susp <= 1'b1;
    end

    // Reset request: set by command, cleared when the reset sequence ends
    always_ff @(posedge clk) begin
        if (!rst_n || !live_d)           rst <= 1'b0;
        else if (rst_done)               rst <= 1'b0;
        else if (cmd.set_rst && conn)    rst <= 1'b1;
    end

    // Connect-change flag: any set cause wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)        chg <= 1'b0;
        else if (chg_set)  chg <= 1'b1;
        else if (cmd.clr_chg) chg <= 1'b0;
    end

    AST_IDLE_WHEN_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
        !conn |-> !(ena || susp || rst)); // R10
    AST_CHG_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.clr_chg && !attach_evt && !cmd.set_ena && !cmd.set_susp &&
         !cmd.set_rst && !hub_rst_done) |=> !chg); // R3
    AST_IDLE_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd.set_ena || cmd.set_susp || cmd.set_rst) && !conn) |=> chg); // R4
    AST_IDLE_CMD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.set_ena && !conn) |=> !ena); // R4

endmodule

// File: rtl/rhp_port.sv
// One downstream port: decodes the write word into commands, instantiates the
// power and status logic, and builds the read word.
module rhp_port
    import rhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pres_in,
    input  logic              lowspd_in,
    input  logic              ovc_in,
    input  logic              rst_done,
    input  logic              glob_on,
    input  logic              glob_off,
    input  logic              hub_rst_done,
    input  logic              per_port_ctl,
    input  logic              nonremovable,
    input  logic              sw_supported,
    output logic [WORD_W-1:0] rword,
    output logic              pwr,
    output logic              ena,
    output logic              susp,
    output logic              rst
);

    port_cmd_t  cmd;
    port_view_t view;
    logic       pwr_next;
    logic       conn;
    logic       chg;

    // Turn the written 1 bits into commands
    always_comb begin
        cmd.clr_ena  = wr && wdata[B_CONN];
        cmd.set_ena  = wr && wdata[B_ENA];
        cmd.set_susp = wr && wdata[B_SUSP];
        cmd.clr_susp = wr && wdata[B_OVC];
        cmd.set_rst  = wr && wdata[B_RST];
        cmd.pwr_on   = wr && wdata[B_PWR];
        cmd.pwr_off  = wr && wdata[B_LOWSPD];
        cmd.clr_chg  = wr && wdata[B_CHG];
    end

    rhp_power_ctl u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .per_port_ctl (per_port_ctl),
        .sw_supported (sw_supported),
        .cmd_on       (cmd.pwr_on),
        .cmd_off      (cmd.pwr_off),
        .glob_on      (glob_on),
        .glob_off     (glob_off),
        .ovc          (ovc_in),
        .pwr_now      (pwr),
        .pwr_next     (pwr_next)
    );

    rhp_status_regs u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .pres_in      (pres_in),
        .pwr_now      (pwr),
        .pwr_next     (pwr_next),
        .rst_done     (rst_done),
        .hub_rst_done (hub_rst_done),
        .nonremovable (nonremovable),
        .conn         (conn),
        .ena          (ena),
        .susp         (susp),
        .rst          (rst),
        .chg          (chg)
    );

    // Assemble the read view; low speed is only meaningful while connected
    always_comb begin
        view.conn   = conn;
        view.ena    = ena;
        view.susp   = susp;
        view.ovc    = ovc_in;
        view.rst    = rst;
        view.pwr    = pwr;
        view.lowspd = lowspd_in && conn;
        view.chg    = chg;
    end

    assign rword = pack_view(view);

endmodule

// File: rtl/rh_port_csr.sv
// Root hub port register array: one rhp_port per downstream port, a shared
// write path steered by wr_port, and a combinational read mux on rd_port.
// Assumes every input is synchronous to clk; the pulse inputs last one cycle.
module rh_port_csr
    import rhp_pkg::*;
#(
    parameter int NPORTS = 2,
    localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_port,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PIDX_W-1:0] rd_port,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NPORTS-1:0] dev_present,
    input  logic [NPORTS-1:0] dev_lowspeed,
    input  logic [NPORTS-1:0] overcurrent,
    input  logic [NPORTS-1:0] reset_done,
    input  logic              glob_pwr_on,
    input  logic              glob_pwr_off,
    input  logic              hub_reset_done,
    input  logic              pwr_per_port_mode,
    input  logic [NPORTS-1:0] pwr_mask,
    input  logic [NPORTS-1:0] dev_nonremovable,
    input  logic              pwr_sw_supported,
    output logic [NPORTS-1:0] port_power,
    output logic [NPORTS-1:0] port_enable,
    output logic [NPORTS-1:0] port_suspend,
    output logic [NPORTS-1:0] port_reset
);

    logic [WORD_W-1:0] rwords [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic sel;
        assign sel = wr_en && (int'(wr_port) == p);

        rhp_port u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr           (sel),
            .wdata        (wr_data),
            .pres_in      (dev_present[p]),
            .lowspd_in    (dev_lowspeed[p]),
            .ovc_in       (overcurrent[p]),
            .rst_done     (reset_done[p]),
            .glob_on      (glob_pwr_on),
            .glob_off     (glob_pwr_off),
            .hub_rst_done (hub_reset_done),
            .per_port_ctl (pwr_per_port_mode && pwr_mask[p]),
            .nonremovable (dev_nonremovable[p]),
            .sw_supported (pwr_sw_supported),
            .rword        (rwords[p]),
            .pwr          (port_power[p]),
            .ena          (port_enable[p]),
            .susp         (port_suspend[p]),
            .rst          (port_reset[p])
        );
    end

    // Read mux; an index past the last port reads zero
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (int'(rd_port) == p) rd_data = rwords[p];
        end
    end

    // Reserved write bits are decoded nowhere
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[WORD_W-1:B_CHG+1], wr_data[B_CHG-1:B_LOWSPD+1],
                              wr_data[B_PWR-1:B_RST+1]};

endmodule

// File: tb/test_rh_port_csr.sv
module test_rh_port_csr;

    localparam int NP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_port = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_port = '0;
    logic [31:0] rd_data;
    logic [NP-1:0] dev_present = '0, dev_lowspeed = '0, overcurrent = '0, reset_done = '0;
    logic        glob_pwr_on = 1'b0, glob_pwr_off = 1'b0, hub_reset_done = 1'b0;
    logic        pwr_per_port_mode = 1'b0, pwr_sw_supported = 1'b1;
    logic [NP-1:0] pwr_mask = '0, dev_nonremovable = '0;
    logic [NP-1:0] port_power, port_enable, port_suspend, port_reset;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rh_port_csr #(.NPORTS(NP)) i_rh_port_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_port(rd_port), .rd_data(rd_data), .dev_present(dev_present),
        .dev_lowspeed(dev_lowspeed), .overcurrent(overcurrent), .reset_done(reset_done),
        .glob_pwr_on(glob_pwr_on), .glob_pwr_off(glob_pwr_off), .hub_reset_done(hub_reset_done),
        .pwr_per_port_mode(pwr_per_port_mode), .pwr_mask(pwr_mask),
        .dev_nonremovable(dev_nonremovable), .pwr_sw_supported(pwr_sw_supported),
        .port_power(port_power), .port_enable(port_enable), .port_suspend(port_suspend),
        .port_reset(port_reset));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int p, output logic [31:0] v);
        rd_port = 1'(p);
        #1 v = rd_data;
    endtask

    task automatic wr(input int p, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_port = 1'(p); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic glob(input logic on);
        @(negedge clk);
        if (on) glob_pwr_on = 1'b1; else glob_pwr_off = 1'b1;
        @(negedge clk);
        glob_pwr_on = 1'b0; glob_pwr_off = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v); chk("R1 port0 word", v, 32'h0);
        rd(1, v); chk("R1 port1 word", v, 32'h0);
        chk("R1 power", 32'(port_power), 32'h0);
    endtask

    task automatic t_global();
        logic [31:0] v;
        glob(1'b1);
        chk("R8 global on", 32'(port_power), 32'h3);
        rd(0, v); chk("R8 power bit", v & 32'h100, 32'h100);
        wr(0, 32'h200);
        chk("R8 write off ignored", 32'(port_power), 32'h3);
        glob(1'b0);
        chk("R8 global off", 32'(port_power), 32'h0);
        wr(0, 32'h100);
        chk("R8 write on ignored", 32'(port_power), 32'h0);
        glob(1'b1);
    endtask

    task automatic t_perport();
        pwr_per_port_mode = 1'b1; pwr_mask = 2'b01;
        glob(1'b0);
        chk("R7 masked port keeps power", 32'(port_power), 32'h1);
        wr(0, 32'h200);
        chk("R6 write off", 32'(port_power), 32'h0);
        wr(0, 32'h100);
        chk("R7 write on", 32'(port_power), 32'h1);
        glob(1'b1);
        chk("R8 unmasked port global on", 32'(port_power), 32'h3);
    endtask

    task automatic t_connect();
        logic [31:0] v;
        @(negedge clk); dev_present[0] = 1'b1;
        @(negedge clk);
        rd(0, v); chk("R2 attach", v, 32'h0001_0101);
        dev_lowspeed[0] = 1'b1; dev_lowspeed[1] = 1'b1;
        rd(0, v); chk("R6 low speed shown", v, 32'h0001_0301);
        rd(1, v); chk("R6 low speed hidden", v, 32'h0000_0100);
        dev_lowspeed[1] = 1'b0;
        wr(0, 32'h0);
        rd(0, v); chk("R3 zero write keeps flag", v, 32'h0001_0301);
        wr(0, 32'h0001_0000);
        rd(0, v); chk("R3 clear flag", v, 32'h0000_0301);
    endtask

    task automatic t_cmds();
        logic [31:0] v;
        wr(0, 32'h2);  rd(0, v); chk("R13 set enable", v, 32'h303);
        chk("R13 enable out", 32'(port_enable), 32'h1);
        wr(0, 32'h4);  rd(0, v); chk("R13 set suspend", v, 32'h307);
        wr(0, 32'h8);  rd(0, v); chk("R13 clear suspend", v, 32'h303);
        wr(0, 32'h10); rd(0, v); chk("R13 set reset", v, 32'h313);
        chk("R13 reset out", 32'(port_reset), 32'h1);
        @(negedge clk); reset_done[0] = 1'b1;
        @(negedge clk); reset_done[0] = 1'b0;
        rd(0, v); chk("R13 reset done", v, 32'h303);
        wr(0, 32'h1);  rd(0, v); chk("R13 clear enable", v, 32'h301);
    endtask

    task automatic t_idle_cmd();
        logic [31:0] v;
        wr(1, 32'h16);
        rd(1, v); chk("R4 idle command flags", v, 32'h0001_0100);
        chk("R4 no enable/suspend/reset",
            32'({port_enable[1], port_suspend[1], port_reset[1]}), 32'h0);
        wr(1, 32'h0001_0000);
        rd(1, v); chk("R3 clear after idle cmd", v, 32'h100);
    endtask

    task automatic t_nonremovable();
        logic [31:0] v;
        dev_nonremovable[1] = 1'b1;
        @(negedge clk); dev_present[1] = 1'b1;
        @(negedge clk);
        rd(1, v); chk("R5 attach no flag", v, 32'h101);
        @(negedge clk); hub_reset_done = 1'b1;
        @(negedge clk); hub_reset_done = 1'b0;
        rd(1, v); chk("R5 flag after hub reset", v, 32'h0001_0101);
    endtask

    task automatic t_overcurrent();
        logic [31:0] v;
        wr(0, 32'h2);
        @(negedge clk); overcurrent[0] = 1'b1;
        @(negedge clk);
        rd(0, v); chk("R9 R10 overcurrent word", v, 32'h8);
        wr(0, 32'h100);
        chk("R9 overcurrent beats power on", 32'(port_power[0]), 32'h0);
        overcurrent[0] = 1'b0;
        wr(0, 32'h100);
        rd(0, v); chk("R10 repower leaves enable off", v, 32'h301);
    endtask

    task automatic t_noswitch();
        logic [31:0] v;
        glob(1'b0);
        chk("R8 port1 off", 32'(port_power), 32'h1);
        rd(1, v); chk("R10 unpowered reads idle", v, 32'h0001_0000);
        pwr_sw_supported = 1'b0;
        #1 chk("R11 power forced", 32'(port_power), 32'h3);
        rd(1, v); chk("R11 power bit", v & 32'h100, 32'h100);
        glob(1'b0);
        chk("R11 global off no effect", 32'(port_power), 32'h3);
    endtask

    task automatic t_reserved();
        logic [31:0] v0, v1;
        rd(0, v0); chk("R12 reserved read zero", v0 & 32'hFFFE_FCE0, 32'h0);
        wr(0, 32'hFFFE_FCE0);
        rd(0, v1); chk("R12 reserved write no effect", v1, v0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_perport();
        t_connect();
        t_cmds();
        t_idle_cmd();
        t_nonremovable();
        t_overcurrent();
        t_noswitch();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule